// File: doc/BRIEF.md
# Differential QPSK Decision and Bit Error Counter

This block sits at the tail of a dual-polarisation coherent receiver. Each cycle with `in_valid` high it accepts one recovered complex symbol per polarisation tributary. It slices each symbol to a quadrant by the signs of its real and imaginary parts. It then decodes the symbol differentially as the quadrant step from the previous decision, and turns that step into a Gray-coded bit pair.

Each tributary carries its own bit tracker. The tracker first aligns a local degree-7 pseudo-random reference (x^7 + x^6 + 1) to the decoded bits. Once the reference is aligned, it compares every later bit with the reference and counts errors and compared bits in saturating counters. These counters can be read at any time. When a burst of errors shows the alignment is lost, the tracker drops lock and searches again. A synchronous clear input zeroes the counters without touching lock.

Top module: `dqpsk_diff_errcnt`

## Requirements
- R1: A symbol's quadrant index comes from the signs of its components: 0 for (re>=0, im>=0), 1 for (re<0, im>=0), 2 for (re<0, im<0), 3 for (re>=0, im<0). A zero component counts as non-negative.
- R2: The decoded step is (current quadrant - previous quadrant) mod 4. The previous quadrant is 0 after reset and is updated only by valid symbols.
- R3: A step maps to the bit pair (first, second) as 0->00, 1->01, 2->11, 3->10. The first bit is the earlier one in the reference stream.
- R4: The two tributaries (a and b) are decoded, aligned and counted independently of each other.
- R5: Cycles with `in_valid` low change no decision state, lock or counter, whatever the sample inputs carry.
- R6: While searching, the reference history is loaded from received bits. The first 7 bits after a search starts are not checked. Each later bit is checked against h[n-7] xor h[n-6]. A mismatch restarts the run. Lock is taken after the symbol that brings the run of consecutive matching checked bits to 64 or more, which is symbol 36 of a clean stream.
- R7: While locked, the reference runs free. From the symbol after the one that took lock, every symbol adds 2 to the bit counter and adds its mismatching bits to the error counter. Nothing is counted while searching.
- R8: After lock, the bits are grouped into successive 64-bit windows. If a window's errors exceed 16, lock drops and a new search begins. The counters then hold their values.
- R9: The error and bit counters are CNT_W bits wide and stick at their all-ones value instead of wrapping.
- R10: A high `clr` zeroes both counters of both tributaries on the next edge and leaves lock unchanged.
- R11: After reset, both lock flags are low and all counters are zero.
- R12: A symbol presented at one edge changes the counters and lock flags at the second edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all counters |
| in_valid | input | 1 | Symbol strobe for both tributaries |
| pol_a_re | input | SAMPLE_W | Tributary a real part, signed |
| pol_a_im | input | SAMPLE_W | Tributary a imaginary part, signed |
| pol_b_re | input | SAMPLE_W | Tributary b real part, signed |
| pol_b_im | input | SAMPLE_W | Tributary b imaginary part, signed |
| lock_a | output | 1 | Tributary a reference aligned |
| lock_b | output | 1 | Tributary b reference aligned |
| err_cnt_a | output | CNT_W | Tributary a bit errors |
| err_cnt_b | output | CNT_W | Tributary b bit errors |
| bit_cnt_a | output | CNT_W | Tributary a compared bits |
| bit_cnt_b | output | CNT_W | Tributary b compared bits |

## Verification
The bench builds the block with CNT_W = 8 and keeps the default 64-bit lock run, 64-bit window and loss limit of 16. The narrow counters let a few hundred symbols drive both the bit and the error counter to their sticking value. The loss limit can be approached exactly with a pattern of 16 errors per window that must not drop lock, and crossed with an inverted burst that must. Samples of 8 bits make zero and full-scale negative components frequent under random stimulus.

// File: rtl/dqd_pkg.sv
package dqd_pkg;

    localparam int PRBS_DEG = 7;
    localparam int POL_CNT  = 2;

    typedef logic [1:0] quad_t;

    typedef struct packed {
        logic first;
        logic second;
    } dibit_t;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } trk_state_e;

    // Quadrant index from the two sign bits (zero is non-negative).
    function automatic quad_t quad_of(input logic re_neg, input logic im_neg);
        return {im_neg, re_neg ^ im_neg};
    endfunction

    // Gray map of a quadrant step onto a bit pair.
    function automatic dibit_t gray_of(input quad_t step);
        dibit_t r;
        r.first  = step[1];
        r.second = step[1] ^ step[0];
        return r;
    endfunction

    // Next reference bit for x^7 + x^6 + 1, history bit 0 is the newest.
    function automatic logic prbs_next(input logic [PRBS_DEG-1:0] h);
        return h[PRBS_DEG-1] ^ h[PRBS_DEG-2];
    endfunction

endpackage

// File: rtl/dqd_slicer.sv
module dqd_slicer
    import dqd_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       vld,
    input  logic signed [SAMPLE_W-1:0] re,
    input  logic signed [SAMPLE_W-1:0] im,
    output logic                       dec_vld,
    output dibit_t                     dec
);

    quad_t q_now;
    quad_t q_prev;

    always_comb begin
        q_now = quad_of(re[SAMPLE_W-1], im[SAMPLE_W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_prev  <= '0;
            dec_vld <= 1'b0;
            dec     <= '0;
        end else begin
            dec_vld <= vld;
            if (vld) begin
                q_prev <= q_now;
                dec    <= gray_of(quad_t'(q_now - q_prev));
            end
        end
    end

endmodule

// File: rtl/dqd_tracker.sv
module dqd_tracker
    import dqd_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int LOCK_BITS  = 64,
    parameter int WIN_BITS   = 64,
    parameter int LOSS_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             sym_vld,
    input  dibit_t           sym,
    output logic             locked,
    output logic [CNT_W-1:0] err_cnt,
    output logic [CNT_W-1:0] bit_cnt
);

    localparam int FILL_W = $clog2(PRBS_DEG + 1);
    localparam int RUN_W  = $clog2(LOCK_BITS + 2) + 1;
    localparam int WIN_W  = $clog2(WIN_BITS + 2) + 1;
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(PRBS_DEG);

    trk_state_e          state;
    logic [PRBS_DEG-1:0] hist, h1, h2;
    logic [FILL_W-1:0]   fill, fill1, fill2;
    logic [RUN_W-1:0]    run, run1, run2;
    logic [WIN_W-1:0]    win_bits, win_err, win_bits_n, win_err_n;
    logic                is_lock, p1, p2, chk1, chk2, m1, m2;
    logic                goes_lock, lose, win_end;
    logic [1:0]          nerr;
    logic [CNT_W:0]      err_sum, bit_sum;

    assign is_lock = (state == ST_LOCKED);
    assign locked  = is_lock;

    // Two bits per symbol, evaluated in stream order.
    always_comb begin
        p1    = prbs_next(hist);
        chk1  = is_lock || (fill == FILL_FULL);
        m1    = chk1 && (p1 != sym.first);
        h1    = {hist[PRBS_DEG-2:0], is_lock ? p1 : sym.first};
        fill1 = (fill == FILL_FULL) ? fill : fill + 1'b1;
        run1  = chk1 ? (m1 ? '0 : run + 1'b1) : run;

        p2    = prbs_next(h1);
        chk2  = is_lock || (fill1 == FILL_FULL);
        m2    = chk2 && (p2 != sym.second);
        h2    = {h1[PRBS_DEG-2:0], is_lock ? p2 : sym.second};
        fill2 = (fill1 == FILL_FULL) ? fill1 : fill1 + 1'b1;
        run2  = chk2 ? (m2 ? '0 : run1 + 1'b1) : run1;

        goes_lock  = (run2 >= RUN_W'(LOCK_BITS));
        nerr       = {1'b0, m1} + {1'b0, m2};
        win_err_n  = win_err + WIN_W'(nerr);
        win_bits_n = win_bits + WIN_W'(2);
        lose       = (win_err_n > WIN_W'(LOSS_LIMIT));
        win_end    = (win_bits_n >= WIN_W'(WIN_BITS));

        err_sum = {1'b0, err_cnt} + (CNT_W + 1)'(nerr);
        bit_sum = {1'b0, bit_cnt} + (CNT_W + 1)'(2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_SEARCH;
            hist     <= '0;
            fill     <= '0;
            run      <= '0;
            win_bits <= '0;
            win_err  <= '0;
        end else if (sym_vld) begin
            hist <= h2;
            if (!is_lock) begin
                fill <= fill2;
                if (goes_lock) begin
                    state    <= ST_LOCKED;
                    run      <= '0;
                    win_bits <= '0;
                    win_err  <= '0;
                end else begin
                    run <= run2;
                end
            end else if (lose) begin
                state    <= ST_SEARCH;
                fill     <= '0;
                run      <= '0;
                win_bits <= '0;
                win_err  <= '0;
            end else if (win_end) begin
                win_bits <= '0;
                win_err  <= '0;
            end else begin
                win_bits <= win_bits_n;
                win_err  <= win_err_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err_cnt <= '0;
            bit_cnt <= '0;
        end else if (sym_vld && is_lock) begin
            err_cnt <= err_sum[CNT_W] ? '1 : err_sum[CNT_W-1:0];
            bit_cnt <= bit_sum[CNT_W] ? '1 : bit_sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/dqpsk_diff_errcnt.sv
module dqpsk_diff_errcnt
    import dqd_pkg::*;
#(
    parameter int SAMPLE_W   = 8,
    parameter int CNT_W      = 32,
    parameter int LOCK_BITS  = 64,
    parameter int WIN_BITS   = 64,
    parameter int LOSS_LIMIT = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] pol_a_re,
    input  logic signed [SAMPLE_W-1:0] pol_a_im,
    input  logic signed [SAMPLE_W-1:0] pol_b_re,
    input  logic signed [SAMPLE_W-1:0] pol_b_im,
    output logic                       lock_a,
    output logic                       lock_b,
    output logic [CNT_W-1:0]           err_cnt_a,
    output logic [CNT_W-1:0]           err_cnt_b,
    output logic [CNT_W-1:0]           bit_cnt_a,
    output logic [CNT_W-1:0]           bit_cnt_b
);

    logic signed [SAMPLE_W-1:0] re_v [POL_CNT];
    logic signed [SAMPLE_W-1:0] im_v [POL_CNT];
    logic                       dv_v [POL_CNT];
    dibit_t                     dec_v [POL_CNT];
    logic                       lk_v [POL_CNT];
    logic [CNT_W-1:0]           ec_v [POL_CNT];
    logic [CNT_W-1:0]           bc_v [POL_CNT];

    assign re_v[0] = pol_a_re;
    assign im_v[0] = pol_a_im;
    assign re_v[1] = pol_b_re;
    assign im_v[1] = pol_b_im;

    for (genvar g = 0; g < POL_CNT; g++) begin : g_lane
        dqd_slicer #(.SAMPLE_W(SAMPLE_W)) u_slice (
            .clk     (clk),
            .rst     (rst),
            .vld     (in_valid),
            .re      (re_v[g]),
            .im      (im_v[g]),
            .dec_vld (dv_v[g]),
            .dec     (dec_v[g])
        );

        dqd_tracker #(
            .CNT_W      (CNT_W),
            .LOCK_BITS  (LOCK_BITS),
            .WIN_BITS   (WIN_BITS),
            .LOSS_LIMIT (LOSS_LIMIT)
        ) u_track (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr),
            .sym_vld (dv_v[g]),
            .sym     (dec_v[g]),
            .locked  (lk_v[g]),
            .err_cnt (ec_v[g]),
            .bit_cnt (bc_v[g])
        );
    end

    assign lock_a    = lk_v[0];
    assign lock_b    = lk_v[1];
    assign err_cnt_a = ec_v[0];
    assign err_cnt_b = ec_v[1];
    assign bit_cnt_a = bc_v[0];
    assign bit_cnt_b = bc_v[1];

endmodule

// File: rtl/dqpsk_diff_errcnt_chk.sv
module dqpsk_diff_errcnt_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             in_valid,
    input logic             lock_a,
    input logic             lock_b,
    input logic [CNT_W-1:0] err_cnt_a,
    input logic [CNT_W-1:0] err_cnt_b,
    input logic [CNT_W-1:0] bit_cnt_a,
    input logic [CNT_W-1:0] bit_cnt_b
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    AST_LOCK_A_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_a) |-> $past(in_valid, 2));  // R5
    AST_LOCK_B_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_b) |-> $past(in_valid, 2));  // R5
    AST_ERR_A_ONLY_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && !$stable(err_cnt_a)) |-> $past(lock_a));  // R7
    AST_ERR_B_ONLY_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && !$stable(err_cnt_b)) |-> $past(lock_b));  // R7
    AST_BITS_A_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && !$stable(bit_cnt_a)) |->
        (bit_cnt_a == $past(bit_cnt_a) + CNT_W'(2) || bit_cnt_a == CMAX));  // R9
    AST_BITS_B_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && !$stable(bit_cnt_b)) |->
        (bit_cnt_b == $past(bit_cnt_b) + CNT_W'(2) || bit_cnt_b == CMAX));  // R9
    AST_ERR_A_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$past(clr) |-> err_cnt_a >= $past(err_cnt_a));  // R9
    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (err_cnt_a == '0 && bit_cnt_a == '0 && err_cnt_b == '0 && bit_cnt_b == '0));  // R10
    AST_CLR_KEEPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (clr && !in_valid && !$past(in_valid)) |=> $stable(lock_a) && $stable(lock_b));  // R10

endmodule

bind dqpsk_diff_errcnt dqpsk_diff_errcnt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .in_valid  (in_valid),
    .lock_a    (lock_a),
    .lock_b    (lock_b),
    .err_cnt_a (err_cnt_a),
    .err_cnt_b (err_cnt_b),
    .bit_cnt_a (bit_cnt_a),
    .bit_cnt_b (bit_cnt_b)
);

// File: tb/sim_dqpsk_diff_errcnt.sv
module sim_dqpsk_diff_errcnt;

    localparam int SW = 8;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic in_valid = 1'b0;
    logic signed [SW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic lock_a, lock_b;
    logic [CW-1:0] err_a, err_b, bits_a, bits_b;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [6:0] gh_a = 7'h5A, gh_b = 7'h33;
    logic [1:0] gq_a = 2'd0, gq_b = 2'd0;
    int exp_ea, exp_eb;
    logic [CW-1:0] hold_e, hold_b;

    always #5 clk = ~clk;

    dqpsk_diff_errcnt #(.SAMPLE_W(SW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .pol_a_re(a_re), .pol_a_im(a_im), .pol_b_re(b_re), .pol_b_im(b_im),
        .lock_a(lock_a), .lock_b(lock_b),
        .err_cnt_a(err_a), .err_cnt_b(err_b),
        .bit_cnt_a(bits_a), .bit_cnt_b(bits_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sample for a quadrant: R1 signs, zero treated as non-negative.
    function automatic logic signed [SW-1:0] comp(input bit neg);
        int m;
        if (neg) m = -(1 + int'($urandom % 128));
        else m = ($urandom % 4 == 0) ? 0 : int'($urandom % 128);
        return SW'(m);
    endfunction

    // Next reference pair, error mask applied, Gray decoded (R3) and
    // accumulated into the quadrant (R2).
    task automatic gen(inout logic [6:0] h, inout logic [1:0] q, input logic [1:0] mask,
                       output logic signed [SW-1:0] re, output logic signed [SW-1:0] im);
        logic f, s;
        logic [1:0] d;
        f = h[6] ^ h[5];
        h = {h[5:0], f};
        s = h[6] ^ h[5];
        h = {h[5:0], s};
        f = f ^ mask[1];
        s = s ^ mask[0];
        d = {f, f ^ s};
        q = q + d;
        re = comp(q == 2'd1 || q == 2'd2);
        im = comp(q == 2'd2 || q == 2'd3);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        a_re = SW'($urandom); a_im = SW'($urandom);
        b_re = SW'($urandom); b_im = SW'($urandom);
    endtask

    task automatic send(input logic [1:0] ma, input logic [1:0] mb);
        logic signed [SW-1:0] r, i;
        @(negedge clk);
        gen(gh_a, gq_a, ma, r, i); a_re = r; a_im = i;
        gen(gh_b, gq_b, mb, r, i); b_re = r; b_im = i;
        in_valid = 1'b1;
    endtask

    // Symbol plus an occasional invalid cycle carrying garbage (R5).
    task automatic send_gap(input logic [1:0] ma, input logic [1:0] mb);
        send(ma, mb);
        if ($urandom % 4 == 0) idle();
    endtask

    task automatic settle();
        repeat (3) idle();
    endtask

    function automatic logic [1:0] one_bit();
        return ($urandom % 2) ? 2'b10 : 2'b01;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        if (!done) $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 lock_a", lock_a, 0);
        chk("R11 lock_b", lock_b, 0);
        chk("R11 err_a", err_a, 0);
        chk("R11 bits_b", bits_b, 0);

        // R6 acquisition on a clean stream: locks exactly at symbol 36
        for (int k = 0; k < 35; k++) send_gap(2'b00, 2'b00);
        settle();
        chk("R6 no lock at 35 a", lock_a, 0);
        chk("R6 no lock at 35 b", lock_b, 0);
        send(2'b00, 2'b00);
        settle();
        chk("R6 lock at 36 a", lock_a, 1);
        chk("R6 lock at 36 b", lock_b, 1);
        chk("R7 nothing counted before lock", bits_a, 0);

        // R7 R1 R2 R3 R4: random samples with injected bit errors per lane
        exp_ea = 0; exp_eb = 0;
        for (int k = 0; k < 100; k++) begin
            logic [1:0] ma, mb;
            ma = (k % 4 == 0) ? one_bit() : 2'b00;
            mb = (k % 4 == 2 && k % 3 == 0) ? 2'b11 : 2'b00;
            exp_ea += (ma != 2'b00) ? 1 : 0;
            exp_eb += (mb != 2'b00) ? 2 : 0;
            send_gap(ma, mb);
        end
        settle();
        chk("R7 err_a", err_a, exp_ea);
        chk("R7 bits_a", bits_a, 200);
        chk("R4 err_b", err_b, exp_eb);
        chk("R4 bits_b", bits_b, 200);

        // R10 clear keeps lock
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        settle();
        chk("R10 err_a cleared", err_a, 0);
        chk("R10 bits_b cleared", bits_b, 0);
        chk("R10 lock_a kept", lock_a, 1);

        // R5 long garbage with valid low
        repeat (30) idle();
        chk("R5 bits_a unchanged", bits_a, 0);
        chk("R5 lock_b unchanged", lock_b, 1);

        // R12 latency of one errored symbol
        send(2'b01, 2'b00);
        idle();
        chk("R12 no change after one edge", err_a, 0);
        idle();
        chk("R12 change after two edges", err_a, 1);
        for (int k = 0; k < 9; k++) send_gap(2'b00, 2'b00);
        settle();
        chk("R7 bits_a after 10", bits_a, 20);
        chk("R2 differential state kept over gaps", err_a, 1);

        // R8 inverted burst on lane a drops lock, lane b unaffected (R4)
        for (int k = 0; k < 40; k++) send_gap(2'b11, 2'b00);
        settle();
        chk("R8 lock_a dropped", lock_a, 0);
        chk("R4 lock_b kept", lock_b, 1);
        hold_e = err_a; hold_b = bits_a;
        for (int k = 0; k < 20; k++) send_gap(2'b11, 2'b00);
        settle();
        chk("R8 err_a held", err_a, hold_e);
        chk("R8 bits_a held", bits_a, hold_b);
        chk("R4 bits_b", bits_b, 140);

        // R6 relock on clean data
        for (int k = 0; k < 50; k++) send_gap(2'b00, 2'b00);
        settle();
        chk("R6 relock a", lock_a, 1);

        // R8 exactly 16 errors per window keeps lock; R9 saturation
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        for (int k = 0; k < 520; k++) begin
            send_gap((k % 4 == 0) ? one_bit() : 2'b00, (k % 4 == 1) ? 2'b11 : 2'b00);
        end
        settle();
        chk("R8 lock_b at limit", lock_b, 1);
        chk("R9 bits_a sticks", bits_a, 255);
        chk("R9 err_a", err_a, 130);
        chk("R9 err_b sticks", err_b, 255);
        chk("R9 bits_b sticks", bits_b, 255);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule